// File: doc/BRIEF.md
# Register-Triggered Signed Multiply-Accumulate Unit

This block sits on the byte-wide register bus of a small 8-bit processor. It gives software a signed multiply and a signed multiply-accumulate without any start bit or busy flag. The operation is a side effect of storing an operand: the new result can be read in the very next bus cycle.

There are two independent operand pairs. Storing either byte of the multiply pair forms the 16-bit signed product of that pair, which is read back as a low byte and a high byte. Storing either byte of the accumulate pair multiplies that pair and adds the sign-extended product into a 32-bit signed running total, which is read back as four bytes. A write-only strobe address zeroes the total. All other bus activity leaves the results alone.

Top module: `sgn_mac_regs`

## Requirements
- R1: After reset, every readable address returns 0x00. The four operands, the product and the accumulator all start at zero.
- R2: A write to 0x0 (multiply operand A) or 0x1 (multiply operand B) stores the byte. In the following cycle, the signed 16-bit product of the two multiply operands reads back at 0x4 (low byte) and 0x5 (high byte). Operands are 8-bit two's complement.
- R3: Reads of 0x0, 0x1, 0x2 and 0x3 return the operand byte that was last written there.
- R4: A write to 0x2 (accumulate operand A) or 0x3 (accumulate operand B) stores the byte and adds the signed product of the two accumulate operands to the accumulator. The result is visible in the following cycle at 0x6 (bits 7:0), 0x7, 0x8 and 0x9 (bits 31:24). Writing the same value again adds the product again.
- R5: The product is sign-extended to 32 bits before the addition, and the total wraps modulo 2^32. For example, a total of -1 reads FF FF FF FF, and adding 1 to it gives zero.
- R6: A write of any data to 0xA sets all four accumulator bytes to zero. It leaves the operands and the product unchanged.
- R7: Writes to the result addresses 0x4 to 0x9 and to unmapped addresses 0xB to 0xF change nothing. Reads of 0xA to 0xF return 0x00.
- R8: The multiply path and the accumulate path do not affect each other. A multiply-operand write leaves the accumulator unchanged, and an accumulate-operand write leaves the product unchanged.
- R9: The extreme operands -128 × -128 give +16384 (0x4000) on both paths.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 4 | Register address for both reads and writes |
| bus_wr | input | 1 | Write strobe, sampled on the rising edge |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Combinational read data for bus_addr |

## Verification
A corrupted operand register shows up at once when that operand's address is read back. It also shows in the next product or total formed from that operand. A wrong product or a missed sign extension appears at the result addresses one cycle after the triggering write. An accumulator error persists and builds up, so later reads of any total byte expose it. The bench compares the read port against a behavioural model on every clock. A fault therefore shows in the first cycle in which the affected address is on the bus.

// File: rtl/sgn_mac_regs.sv
module sgn_mac_regs #(
  parameter int OPW    = 8,
  parameter int ACCW   = 32,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [OPW-1:0]    bus_wdata,
  output logic [OPW-1:0]    bus_rdata
);
  localparam int PRODW      = 2 * OPW;
  localparam int PROD_BYTES = PRODW / OPW;
  localparam int ACC_BYTES  = ACCW / OPW;
  localparam int A_MX   = 0;
  localparam int A_MY   = 1;
  localparam int A_AX   = 2;
  localparam int A_AY   = 3;
  localparam int A_PROD = 4;
  localparam int A_ACC  = A_PROD + PROD_BYTES;
  localparam int A_CLR  = A_ACC + ACC_BYTES;

  logic signed [OPW-1:0]   mx, my, ax, ay;
  logic signed [PRODW-1:0] prod;
  logic        [ACCW-1:0]  acc;

  wire wr_mx  = bus_wr && (bus_addr == ADDR_W'(A_MX));
  wire wr_my  = bus_wr && (bus_addr == ADDR_W'(A_MY));
  wire wr_ax  = bus_wr && (bus_addr == ADDR_W'(A_AX));
  wire wr_ay  = bus_wr && (bus_addr == ADDR_W'(A_AY));
  wire wr_clr = bus_wr && (bus_addr == ADDR_W'(A_CLR));

  wire signed [OPW-1:0]   wd_s   = $signed(bus_wdata);
  wire signed [OPW-1:0]   mul_a  = wr_mx ? wd_s : mx;
  wire signed [OPW-1:0]   mul_b  = wr_my ? wd_s : my;
  wire signed [OPW-1:0]   mac_a  = wr_ax ? wd_s : ax;
  wire signed [OPW-1:0]   mac_b  = wr_ay ? wd_s : ay;
  wire signed [PRODW-1:0] mul_p  = mul_a * mul_b;
  wire signed [PRODW-1:0] mac_p  = mac_a * mac_b;
  wire        [ACCW-1:0]  mac_px = {{(ACCW-PRODW){mac_p[PRODW-1]}}, mac_p};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mx   <= '0;
      my   <= '0;
      ax   <= '0;
      ay   <= '0;
      prod <= '0;
      acc  <= '0;
    end else begin
      if (wr_mx) mx <= wd_s;
      if (wr_my) my <= wd_s;
      if (wr_ax) ax <= wd_s;
      if (wr_ay) ay <= wd_s;
      if (wr_mx || wr_my) prod <= mul_p;
      if (wr_clr) acc <= '0;
      else if (wr_ax || wr_ay) acc <= acc + mac_px;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == ADDR_W'(A_MX)) bus_rdata = mx;
    if (bus_addr == ADDR_W'(A_MY)) bus_rdata = my;
    if (bus_addr == ADDR_W'(A_AX)) bus_rdata = ax;
    if (bus_addr == ADDR_W'(A_AY)) bus_rdata = ay;
    for (int i = 0; i < PROD_BYTES; i++)
      if (bus_addr == ADDR_W'(A_PROD + i)) bus_rdata = prod[i*OPW +: OPW];
    for (int i = 0; i < ACC_BYTES; i++)
      if (bus_addr == ADDR_W'(A_ACC + i)) bus_rdata = acc[i*OPW +: OPW];
  end

  p_prod_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_mx || wr_my) |=> $stable(prod));

  p_opnd_store_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ax |=> (ax == $signed($past(bus_wdata))));

  p_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_clr |=> (acc == '0) && $stable(prod) && $stable(ax) && $stable(ay));

  p_acc_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_ax || wr_ay || wr_clr) |=> $stable(acc));

  p_acc_sign_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ax || wr_ay) && (acc == '0) && mac_p[PRODW-1] |=> acc[ACCW-1]);
endmodule

// File: tb/sgn_mac_regs_test.sv
`timescale 1ns/100ps
module sgn_mac_regs_test;
  logic       clk = 0;
  logic       rst_n = 0;
  logic [3:0] bus_addr = '0;
  logic       bus_wr = 0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;

  int    n_cmp = 0;
  int    n_bad = 0;
  bit    done = 0;
  string cur_req = "R1";

  sgn_mac_regs uut (.clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
                    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata));

  always #2 clk = ~clk;

  // behavioural reference model
  int m_op[4];
  int m_prod;
  longint m_acc;

  function automatic int sx8(input logic [7:0] v);
    return (v >= 128) ? int'(v) - 256 : int'(v);
  endfunction

  function automatic logic [7:0] model_rd(input logic [3:0] a);
    logic [15:0] p16;
    logic [31:0] a32;
    p16 = 16'(m_prod);
    a32 = 32'(m_acc);
    if (a <= 3) return 8'(m_op[a]);
    if (a == 4) return p16[7:0];
    if (a == 5) return p16[15:8];
    if (a >= 6 && a <= 9) return a32[(int'(a) - 6) * 8 +: 8];
    return 8'h00;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      foreach (m_op[i]) m_op[i] = 0;
      m_prod = 0;
      m_acc = 0;
    end else if (bus_wr) begin
      if (bus_addr <= 3) m_op[bus_addr] = sx8(bus_wdata);
      if (bus_addr == 0 || bus_addr == 1) m_prod = m_op[0] * m_op[1];
      if (bus_addr == 2 || bus_addr == 3) m_acc = (m_acc + m_op[2] * m_op[3]) & 64'hFFFF_FFFF;
      if (bus_addr == 10) m_acc = 0;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      n_cmp++;
      if (bus_rdata !== model_rd(bus_addr)) begin
        n_bad++;
        $display("FAIL %s model compare addr %0h: got %02h expected %02h",
                 cur_req, bus_addr, bus_rdata, model_rd(bus_addr));
      end
    end
  end

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    bus_addr = a; bus_wr = 1; bus_wdata = d;
    @(posedge clk); #1;
    bus_wr = 0;
  endtask

  task automatic rd(input logic [3:0] a, input logic [7:0] exp, input string req);
    bus_addr = a; bus_wr = 0;
    #1;
    n_cmp++;
    if (bus_rdata !== exp) begin
      n_bad++;
      $display("FAIL %s read addr %0h: got %02h expected %02h", req, a, bus_rdata, exp);
    end
    @(posedge clk); #1;
  endtask

  task automatic rd_acc(input logic [31:0] exp, input string req);
    for (int i = 0; i < 4; i++) rd(4'(6 + i), exp[i*8 +: 8], req);
  endtask

  task automatic finish_run();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    #100000;
    n_cmp++; n_bad++;
    $display("FAIL watchdog expired: got running expected finished");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(posedge clk); #1;

    cur_req = "R1";
    for (int a = 0; a < 16; a++) rd(4'(a), 8'h00, "R1");

    cur_req = "R2";
    wr(4'h0, 8'd3);
    rd(4'h4, 8'h00, "R2");
    wr(4'h1, 8'd5);
    rd(4'h4, 8'h0F, "R2");
    rd(4'h5, 8'h00, "R2");
    wr(4'h0, 8'hF9);            // -7 * 5 = -35
    rd(4'h4, 8'hDD, "R2");
    rd(4'h5, 8'hFF, "R2");
    cur_req = "R3";
    rd(4'h0, 8'hF9, "R3");
    rd(4'h1, 8'h05, "R3");
    cur_req = "R9";
    wr(4'h0, 8'h80);
    wr(4'h1, 8'h80);
    rd(4'h4, 8'h00, "R9");
    rd(4'h5, 8'h40, "R9");
    cur_req = "R2";
    wr(4'h0, 8'h7F);            // 127 * -128 = -16256
    rd(4'h4, 8'h80, "R2");
    rd(4'h5, 8'hC0, "R2");
    cur_req = "R8";
    rd_acc(32'h0, "R8");

    cur_req = "R4";
    wr(4'h2, 8'd4);
    rd_acc(32'h0, "R4");
    wr(4'h3, 8'd6);
    rd_acc(32'd24, "R4");
    wr(4'h3, 8'd6);
    rd_acc(32'd48, "R4");
    rd(4'h2, 8'h04, "R3");
    rd(4'h3, 8'h06, "R3");
    cur_req = "R8";
    rd(4'h4, 8'h80, "R8");
    rd(4'h5, 8'hC0, "R8");

    cur_req = "R9";
    wr(4'h2, 8'h80);            // 48 - 768 = -720
    rd_acc(32'hFFFF_FD30, "R5");
    wr(4'h3, 8'h80);            // -720 + 16384 = 15664
    rd_acc(32'h0000_3D30, "R9");

    cur_req = "R6";
    wr(4'hA, 8'h5A);
    rd_acc(32'h0, "R6");
    rd(4'h2, 8'h80, "R6");
    rd(4'h3, 8'h80, "R6");
    rd(4'h4, 8'h80, "R6");

    cur_req = "R5";
    wr(4'h3, 8'h01);            // -128
    rd_acc(32'hFFFF_FF80, "R5");
    wr(4'h2, 8'h7F);            // +127 -> -1
    rd_acc(32'hFFFF_FFFF, "R5");
    wr(4'h2, 8'h01);            // +1 wraps to zero
    rd_acc(32'h0, "R5");

    cur_req = "R4";
    wr(4'h2, 8'h7F);            // +127
    for (int k = 0; k < 301; k++) wr(4'h3, 8'h7F);
    rd_acc(32'h004A_14AC, "R4");

    cur_req = "R7";
    wr(4'h4, 8'h55);
    wr(4'h5, 8'h55);
    wr(4'h7, 8'h55);
    wr(4'h9, 8'h55);
    wr(4'hC, 8'h55);
    wr(4'hF, 8'h55);
    rd(4'h4, 8'h80, "R7");
    rd(4'h5, 8'hC0, "R7");
    rd_acc(32'h004A_14AC, "R7");
    for (int a = 10; a < 16; a++) rd(4'(a), 8'h00, "R7");

    finish_run();
  end
endmodule